// File: doc/BRIEF.md
# Quad-Rate Group-Inverted Data Link

This block is a matched transmitter and receiver for a 64-bit active-low data bus that carries four chunks of a 256-bit line in one common-clock period. The transmitter accepts a line and waits for the next common-clock boundary. It then drives the four chunks on four consecutive fast-clock cycles. For every chunk it decides, independently for each 16-bit group, whether the group goes out inverted. It flags that choice on a per-group wire and adds a per-group parity bit. Each group also has two strobes that take turns marking the chunks.

The receiver watches the falling edges of both strobes of each group. It files even chunks from the positive-phase strobe and odd chunks from the negative-phase strobe. It removes the inversion, checks parity and rebuilds the line. The result is presented for one common-clock period, together with a parity-error flag per chunk. The whole design runs on the fast clock. A free-running 2-bit phase count marks the common-clock periods, and phase 3 closes each period. The bus outputs and bus inputs are separate ports, so that the surrounding logic (or a bench) can loop them back or disturb them.

Top module: `qp_inv_link`

## Requirements
- R1: Chunk b (b = 0 first, 3 last) carries line bits [64b+63:64b]. It is on the bus during phase b of the common period that follows launch. Group g of a chunk uses bus bits [16g+15:16g] and flag, parity and strobe index g.
- R2: A group whose logical value has 9 or more ones is driven with wire level equal to its logical value, and its flag wire is low. Otherwise the wire level is the complement of the logical value and the flag wire is high.
- R3: During chunks 0 and 2 a group's positive-phase strobe is low and its negative-phase strobe is high. During chunks 1 and 3 the levels are reversed. With no chunk on the bus, both strobes are high.
- R4: The electrical level of a group's parity wire equals the XOR of the group's 16 electrical data levels.
- R5: The receiver undoes the inversion and outputs the rebuilt line. rx_valid rises in the cycle after chunk 3 is on the bus and stays high for exactly four cycles, one common period.
- R6: rx_perr bit b, reported with the line, is 1 exactly when some group failed the parity check of R4 in chunk b.
- R7: The data-ready wire is low exactly during the four chunk cycles. The bus-owned wire is low while a line is waiting for launch or being driven.
- R8: tx_start is taken only while tx_ready is high, and tx_ready goes low from the next cycle. A start while tx_ready is low is ignored and changes nothing that is sent. A held line is launched at the next phase-3 edge, so back-to-back lines fill every common period.
- R9: While reset is asserted, tx_ready is high, rx_valid is low, and every bus output wire is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four per common period |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Request to send tx_line |
| tx_line | input | 256 | Line to send |
| tx_ready | output | 1 | High when a start will be taken |
| bus_d_n_o | output | 64 | Driven data wires, active low |
| bus_inv_n_o | output | 4 | Driven per-group inversion flags, active low |
| bus_par_n_o | output | 4 | Driven per-group parity wires |
| bus_stbp_n_o | output | 4 | Driven positive-phase strobes |
| bus_stbn_n_o | output | 4 | Driven negative-phase strobes |
| bus_rdy_n_o | output | 1 | Data-ready wire, low while chunks are valid |
| bus_own_n_o | output | 1 | Bus-owned wire |
| bus_d_n_i | input | 64 | Received data wires |
| bus_inv_n_i | input | 4 | Received inversion flags |
| bus_par_n_i | input | 4 | Received parity wires |
| bus_stbp_n_i | input | 4 | Received positive-phase strobes |
| bus_stbn_n_i | input | 4 | Received negative-phase strobes |
| rx_line | output | 256 | Rebuilt line |
| rx_valid | output | 1 | rx_line valid, one common period |
| rx_perr | output | 4 | Per-chunk parity error |

## Verification
Some rules are checked by the assertions on every cycle. No driven group ever has more than eight low wires. Parity matches the driven data. The strobes of a group are opposite while data is valid, both high when it is not, and switch phase from chunk to chunk. The bus stays owned whenever data is valid or a line is held. rx_valid never lasts a single cycle. Other properties only the scenarios can show: the exact 8-versus-9 inversion boundary, the correct rebuilding of the line through the inversion, that an ignored start leaves no trace, and that a wire disturbed in one chunk raises only that chunk's error bit.

// File: rtl/qpl_pkg.sv
// Shared sizing for the quad-rate inverted link.
// Assumes four chunks per common period (the phase count is 2 bits wide).
package qpl_pkg;
    localparam int N_BEAT = 4;
    localparam int PH_W   = 2;
endpackage

// File: rtl/qpl_inv_enc.sv
// Per-group encoder: picks the inversion from the count of logical ones and
// produces the wire levels, the flag and the parity of the wire levels.
// Assumes active-low signalling: a logical 1 is an electrical 0.
module qpl_inv_enc #(
    parameter int GRP_W = 16
) (
    input  logic [GRP_W-1:0] val_i,
    output logic [GRP_W-1:0] wire_o,
    output logic             inv_n_o,
    output logic             par_o
);
    localparam int CW      = $clog2(GRP_W + 1);
    localparam int INV_MIN = GRP_W / 2 + 1;

    logic [CW-1:0] ones;
    logic          do_inv;

    // Count the bits that would be driven low without inversion.
    always_comb begin
        ones = '0;
        for (int i = 0; i < GRP_W; i++) ones = ones + CW'(val_i[i]);
    end

    // Choose the polarity, then form the wire levels and their parity.
    always_comb begin
        do_inv  = (ones >= CW'(INV_MIN));
        wire_o  = do_inv ? val_i : ~val_i;
        inv_n_o = ~do_inv;
        par_o   = ^wire_o;
    end
endmodule

// File: rtl/qpl_tx.sv
// Transmitter: holds one accepted line, launches it at the phase-3 edge and
// drives one chunk per fast cycle with per-group encoding and strobes.
// Assumes phase_i is a free-running count that is shared with the receiver.
module qpl_tx
    import qpl_pkg::*;
#(
    parameter int GRP_W = 16,
    parameter int N_GRP = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PH_W-1:0]                 phase_i,
    input  logic                            start_i,
    input  logic [N_BEAT*N_GRP*GRP_W-1:0]   line_i,
    output logic                            ready_o,
    output logic [N_GRP*GRP_W-1:0]          d_n_o,
    output logic [N_GRP-1:0]                inv_n_o,
    output logic [N_GRP-1:0]                par_n_o,
    output logic [N_GRP-1:0]                stbp_n_o,
    output logic [N_GRP-1:0]                stbn_n_o,
    output logic                            rdy_n_o,
    output logic                            own_n_o
);
    localparam int BUS_W  = N_GRP * GRP_W;
    localparam int LINE_W = N_BEAT * BUS_W;

    logic              pend_q, act_q;
    logic [LINE_W-1:0] pend_line_q, line_q;
    logic [BUS_W-1:0]  chunk, enc_wire;
    logic [N_GRP-1:0]  enc_inv_n, enc_par;
    logic              at_edge;

    assign at_edge = (phase_i == PH_W'(N_BEAT - 1));

    // Take a line into the hold stage and move it to the driver at the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            act_q       <= 1'b0;
            pend_line_q <= '0;
            line_q      <= '0;
        end else begin
            if (start_i && !pend_q) begin
                pend_q      <= 1'b1;
                pend_line_q <= line_i;
            end
            if (at_edge) begin
                act_q <= pend_q;
                if (pend_q) begin
                    line_q <= pend_line_q;
                    pend_q <= 1'b0;
                end
            end
        end
    end

    // Pick the chunk that matches the current phase.
    always_comb chunk = line_q[phase_i*BUS_W +: BUS_W];

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_enc
            qpl_inv_enc #(.GRP_W(GRP_W)) enc_i (
                .val_i   (chunk[g*GRP_W +: GRP_W]),
                .wire_o  (enc_wire[g*GRP_W +: GRP_W]),
                .inv_n_o (enc_inv_n[g]),
                .par_o   (enc_par[g])
            );
        end
    endgenerate

    // Drive the wires; all of them stay high when no chunk is valid.
    always_comb begin
        d_n_o    = act_q ? enc_wire  : '1;
        inv_n_o  = act_q ? enc_inv_n : '1;
        par_n_o  = act_q ? enc_par   : '1;
        stbp_n_o = {N_GRP{~(act_q && !phase_i[0])}};
        stbn_n_o = {N_GRP{~(act_q &&  phase_i[0])}};
        rdy_n_o  = ~act_q;
        own_n_o  = ~(act_q | pend_q);
        ready_o  = ~pend_q;
    end
endmodule

// File: rtl/qpl_rx_grp.sv
// Receiver for one group: finds falling edges on both strobes and files even
// chunks from the positive strobe and odd chunks from the negative one.
// It decodes the inversion and checks parity per chunk. Assumes the data is
// stable in the cycle where the strobe is first seen low.
module qpl_rx_grp
    import qpl_pkg::*;
#(
    parameter int GRP_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [GRP_W-1:0]          d_n_i,
    input  logic                      inv_n_i,
    input  logic                      par_n_i,
    input  logic                      stbp_n_i,
    input  logic                      stbn_n_i,
    output logic [N_BEAT*GRP_W-1:0]   beats_o,
    output logic [N_BEAT-1:0]         perr_o,
    output logic                      done_o
);
    localparam int HALF = N_BEAT / 2;
    localparam int SW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW   = SW + 1;

    logic                    stbp_q, stbn_q;
    logic [SW-1:0]           sel_p_q, sel_n_q;
    logic [N_BEAT*GRP_W-1:0] store_q;
    logic [N_BEAT-1:0]       perr_q;
    logic                    fall_p, fall_n, bad;
    logic [GRP_W-1:0]        dec;
    logic [BW-1:0]           slot_p, slot_n;

    // Find the edges, decode the chunk and test its parity.
    always_comb begin
        fall_p = stbp_q & ~stbp_n_i;
        fall_n = stbn_q & ~stbn_n_i;
        slot_p = {sel_p_q, 1'b0};
        slot_n = {sel_n_q, 1'b1};
        dec    = inv_n_i ? ~d_n_i : d_n_i;
        bad    = ((^d_n_i) != par_n_i);
        done_o = fall_n && (sel_n_q == SW'(HALF - 1));
    end

    // Track the strobe levels and store each captured chunk in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stbp_q  <= 1'b1;
            stbn_q  <= 1'b1;
            sel_p_q <= '0;
            sel_n_q <= '0;
            store_q <= '0;
            perr_q  <= '0;
        end else begin
            stbp_q <= stbp_n_i;
            stbn_q <= stbn_n_i;
            if (fall_p) begin
                store_q[slot_p*GRP_W +: GRP_W] <= dec;
                perr_q[slot_p]                 <= bad;
                sel_p_q                        <= sel_p_q + 1'b1;
            end
            if (fall_n) begin
                store_q[slot_n*GRP_W +: GRP_W] <= dec;
                perr_q[slot_n]                 <= bad;
                sel_n_q                        <= sel_n_q + 1'b1;
            end
        end
    end

    // Present the stored chunks, with the final one taken live at completion.
    always_comb begin
        beats_o = store_q;
        perr_o  = perr_q;
        if (done_o) begin
            beats_o[(N_BEAT-1)*GRP_W +: GRP_W] = dec;
            perr_o[N_BEAT-1]                   = bad;
        end
    end
endmodule

// File: rtl/qpl_rx.sv
// Receiver: one capture unit per group, then it assembles the line and holds
// it with rx_valid for one common period. Assumes all groups finish in the
// same cycle.
module qpl_rx
    import qpl_pkg::*;
#(
    parameter int GRP_W = 16,
    parameter int N_GRP = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [PH_W-1:0]               phase_i,
    input  logic [N_GRP*GRP_W-1:0]        d_n_i,
    input  logic [N_GRP-1:0]              inv_n_i,
    input  logic [N_GRP-1:0]              par_n_i,
    input  logic [N_GRP-1:0]              stbp_n_i,
    input  logic [N_GRP-1:0]              stbn_n_i,
    output logic [N_BEAT*N_GRP*GRP_W-1:0] line_o,
    output logic                          valid_o,
    output logic [N_BEAT-1:0]             perr_o
);
    localparam int BUS_W  = N_GRP * GRP_W;
    localparam int LINE_W = N_BEAT * BUS_W;

    logic [N_BEAT*GRP_W-1:0] grp_beats [N_GRP];
    logic [N_BEAT-1:0]       grp_perr  [N_GRP];
    logic [N_GRP-1:0]        grp_done;
    logic [LINE_W-1:0]       nxt_line;
    logic [N_BEAT-1:0]       nxt_perr;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            qpl_rx_grp #(.GRP_W(GRP_W)) grp_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .d_n_i    (d_n_i[g*GRP_W +: GRP_W]),
                .inv_n_i  (inv_n_i[g]),
                .par_n_i  (par_n_i[g]),
                .stbp_n_i (stbp_n_i[g]),
                .stbn_n_i (stbn_n_i[g]),
                .beats_o  (grp_beats[g]),
                .perr_o   (grp_perr[g]),
                .done_o   (grp_done[g])
            );
        end
    endgenerate

    // Interleave the group chunks back into line order and merge the errors.
    always_comb begin
        nxt_line = '0;
        nxt_perr = '0;
        for (int b = 0; b < N_BEAT; b++) begin
            for (int g = 0; g < N_GRP; g++) begin
                nxt_line[b*BUS_W + g*GRP_W +: GRP_W] = grp_beats[g][b*GRP_W +: GRP_W];
                nxt_perr[b] = nxt_perr[b] | grp_perr[g][b];
            end
        end
    end

    // Load the result on completion and drop valid at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_o  <= '0;
            perr_o  <= '0;
            valid_o <= 1'b0;
        end else if (&grp_done) begin
            line_o  <= nxt_line;
            perr_o  <= nxt_perr;
            valid_o <= 1'b1;
        end else if (phase_i == PH_W'(N_BEAT - 1)) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/qp_inv_link.sv
// Top: a shared phase count that marks the common periods, the transmitter
// and the receiver. The bus is looped back outside the block.
module qp_inv_link
    import qpl_pkg::*;
#(
    parameter int GRP_W = 16,
    parameter int N_GRP = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tx_start,
    input  logic [N_BEAT*N_GRP*GRP_W-1:0] tx_line,
    output logic                          tx_ready,
    output logic [N_GRP*GRP_W-1:0]        bus_d_n_o,
    output logic [N_GRP-1:0]              bus_inv_n_o,
    output logic [N_GRP-1:0]              bus_par_n_o,
    output logic [N_GRP-1:0]              bus_stbp_n_o,
    output logic [N_GRP-1:0]              bus_stbn_n_o,
    output logic                          bus_rdy_n_o,
    output logic                          bus_own_n_o,
    input  logic [N_GRP*GRP_W-1:0]        bus_d_n_i,
    input  logic [N_GRP-1:0]              bus_inv_n_i,
    input  logic [N_GRP-1:0]              bus_par_n_i,
    input  logic [N_GRP-1:0]              bus_stbp_n_i,
    input  logic [N_GRP-1:0]              bus_stbn_n_i,
    output logic [N_BEAT*N_GRP*GRP_W-1:0] rx_line,
    output logic                          rx_valid,
    output logic [N_BEAT-1:0]             rx_perr
);
    logic [PH_W-1:0] phase_q;

    // Free-running phase count; phase 3 closes a common period.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    qpl_tx #(.GRP_W(GRP_W), .N_GRP(N_GRP)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase_q),
        .start_i  (tx_start),
        .line_i   (tx_line),
        .ready_o  (tx_ready),
        .d_n_o    (bus_d_n_o),
        .inv_n_o  (bus_inv_n_o),
        .par_n_o  (bus_par_n_o),
        .stbp_n_o (bus_stbp_n_o),
        .stbn_n_o (bus_stbn_n_o),
        .rdy_n_o  (bus_rdy_n_o),
        .own_n_o  (bus_own_n_o)
    );

    qpl_rx #(.GRP_W(GRP_W), .N_GRP(N_GRP)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase_q),
        .d_n_i    (bus_d_n_i),
        .inv_n_i  (bus_inv_n_i),
        .par_n_i  (bus_par_n_i),
        .stbp_n_i (bus_stbp_n_i),
        .stbn_n_i (bus_stbn_n_i),
        .line_o   (rx_line),
        .valid_o  (rx_valid),
        .perr_o   (rx_perr)
    );
endmodule

// File: rtl/qpl_chk.sv
// Checker for the link's port-level rules; it is attached to every
// qp_inv_link by the bind below.
module qpl_chk #(
    parameter int GRP_W = 16,
    parameter int N_GRP = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tx_ready,
    input logic [N_GRP*GRP_W-1:0]   bus_d_n_o,
    input logic [N_GRP-1:0]         bus_par_n_o,
    input logic [N_GRP-1:0]         bus_stbp_n_o,
    input logic [N_GRP-1:0]         bus_stbn_n_o,
    input logic                     bus_rdy_n_o,
    input logic                     bus_own_n_o,
    input logic                     rx_valid
);
    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_chk
            p_low_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !bus_rdy_n_o |-> ($countones(~bus_d_n_o[g*GRP_W +: GRP_W]) <= GRP_W/2));
            p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !bus_rdy_n_o |-> (bus_par_n_o[g] == ^bus_d_n_o[g*GRP_W +: GRP_W]));
            p_stb_opposite_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !bus_rdy_n_o |-> (bus_stbp_n_o[g] != bus_stbn_n_o[g]));
            p_stb_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdy_n_o |-> (bus_stbp_n_o[g] && bus_stbn_n_o[g]));
            p_stb_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!bus_rdy_n_o && !bus_stbp_n_o[g]) |=> (!bus_rdy_n_o && !bus_stbn_n_o[g]));
        end
    endgenerate

    p_owned_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdy_n_o |-> !bus_own_n_o);
    p_owned_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> !bus_own_n_o);
    p_valid_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |=> rx_valid);
endmodule

bind qp_inv_link qpl_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_ready     (tx_ready),
    .bus_d_n_o    (bus_d_n_o),
    .bus_par_n_o  (bus_par_n_o),
    .bus_stbp_n_o (bus_stbp_n_o),
    .bus_stbn_n_o (bus_stbn_n_o),
    .bus_rdy_n_o  (bus_rdy_n_o),
    .bus_own_n_o  (bus_own_n_o),
    .rx_valid     (rx_valid)
);

// File: tb/qp_inv_link_tb_top.sv
// Scoreboard bench: a driver task queues the expected lines, and a monitor
// compares rx output and checks the driven wires every cycle.
module qp_inv_link_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GW = 16;
    localparam int NG = 4;
    localparam int BW = GW * NG;
    localparam int LW = 4 * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_start = 1'b0;
    logic [LW-1:0] tx_line = '0;
    logic          tx_ready;
    logic [BW-1:0] d_n_o, d_n_i;
    logic [NG-1:0] inv_n_o, par_n_o, stbp_n_o, stbn_n_o;
    logic          rdy_n, own_n;
    logic [LW-1:0] rx_line;
    logic          rx_valid;
    logic [3:0]    rx_perr;
    logic [BW-1:0] bad_mask = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done_flag = 0;

    logic [LW-1:0] exp_line [$];
    logic [3:0]    exp_perr [$];

    assign d_n_i = d_n_o ^ bad_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    qp_inv_link dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_line(tx_line),
        .tx_ready(tx_ready), .bus_d_n_o(d_n_o), .bus_inv_n_o(inv_n_o),
        .bus_par_n_o(par_n_o), .bus_stbp_n_o(stbp_n_o), .bus_stbn_n_o(stbn_n_o),
        .bus_rdy_n_o(rdy_n), .bus_own_n_o(own_n),
        .bus_d_n_i(d_n_i), .bus_inv_n_i(inv_n_o), .bus_par_n_i(par_n_o),
        .bus_stbp_n_i(stbp_n_o), .bus_stbn_n_i(stbn_n_o),
        .rx_line(rx_line), .rx_valid(rx_valid), .rx_perr(rx_perr)
    );

    task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                         input logic [LW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Group with k logical ones, placed from bit 0 upward.
    function automatic logic [GW-1:0] ones_grp(input int k);
        return GW'((17'd1 << k) - 17'd1);
    endfunction

    // Line whose slot s (chunk*4+group) holds (base + 5*s) mod 17 ones.
    function automatic logic [LW-1:0] mk_line(input int base);
        logic [LW-1:0] l = '0;
        for (int s = 0; s < 16; s++) l[s*GW +: GW] = ones_grp((base + 5*s) % 17);
        return l;
    endfunction

    // Driver: wait for ready, present one start, queue the expected result.
    task automatic send(input logic [LW-1:0] ln, input logic [LW-1:0] expl,
                        input logic [3:0] expp);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_start = 1'b1;
        tx_line  = ln;
        exp_line.push_back(expl);
        exp_perr.push_back(expp);
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_line.size() != 0 || !own_n || rx_valid) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: per-cycle wire checks and scoreboard comparison.
    int hold = 0;
    int beat = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rdy_n) begin
                for (int g = 0; g < NG; g++) begin
                    logic [GW-1:0] w, dec;
                    int lows, ones;
                    w = d_n_o[g*GW +: GW];
                    dec = inv_n_o[g] ? ~w : w;
                    lows = $countones(~w);
                    ones = $countones(dec);
                    check((!inv_n_o[g]) == (ones >= 9), "R2 inversion choice",
                          LW'(inv_n_o[g]), LW'(ones < 9));
                    check(lows <= 8, "R2 low-wire count", LW'(lows), LW'(8));
                    check(par_n_o[g] == ^w, "R4 parity wire", LW'(par_n_o[g]), LW'(^w));
                    check(stbp_n_o[g] == beat[0] && stbn_n_o[g] == !beat[0],
                          "R3 strobe phase", LW'({stbp_n_o[g], stbn_n_o[g]}),
                          LW'({beat[0], !beat[0]}));
                end
                check(!own_n, "R7 owned while ready", LW'(own_n), LW'(0));
                beat = (beat + 1) % 4;
            end else begin
                check(beat == 0, "R7 ready length is four", LW'(beat), LW'(0));
                check(&stbp_n_o && &stbn_n_o, "R3 idle strobes",
                      LW'({stbp_n_o, stbn_n_o}), '1 >> (LW - 2*NG));
                beat = 0;
            end
            if (hold > 0) begin
                check(rx_valid, "R5 valid lasts four cycles", LW'(rx_valid), LW'(1));
                hold--;
            end else if (rx_valid) begin
                if (exp_line.size() == 0) begin
                    check(1'b0, "R8 unexpected line", rx_line, '0);
                end else begin
                    logic [LW-1:0] el;
                    logic [3:0] ep;
                    el = exp_line.pop_front();
                    ep = exp_perr.pop_front();
                    check(rx_line == el, "R1 R5 rebuilt line", rx_line, el);
                    check(rx_perr == ep, "R6 chunk parity flags", LW'(rx_perr), LW'(ep));
                end
                hold = 3;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done_flag) begin
            done_flag = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] a, b, flip;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(tx_ready && !rx_valid, "R9 reset ready/valid",
              LW'({tx_ready, rx_valid}), LW'(2'b10));
        check(&d_n_o && &inv_n_o && &par_n_o && &stbp_n_o && &stbn_n_o && rdy_n && own_n,
              "R9 reset wires high", LW'(d_n_o), '1 >> (LW - BW));
        rst_n = 1'b1;

        // All-zero and all-one lines: no inversion and full inversion (R2).
        send('0, '0, 4'b0);
        send('1, '1, 4'b0);
        wait_idle();

        // 8/9 boundary and mixed counts, sent back to back (R1, R2, R8).
        send(mk_line(8), mk_line(8), 4'b0);
        send(mk_line(9), mk_line(9), 4'b0);
        send(mk_line(3), mk_line(3), 4'b0);
        for (int i = 0; i < 6; i++) begin
            a = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            send(a, a, 4'b0);
        end
        wait_idle();

        // R8: a start while not ready is ignored.
        a = mk_line(12);
        b = ~mk_line(5);
        send(a, a, 4'b0);
        check(!tx_ready, "R8 ready low after accept", LW'(tx_ready), LW'(0));
        tx_start = 1'b1;
        tx_line  = b;
        @(negedge clk);
        tx_start = 1'b0;
        tx_line  = '0;
        wait_idle();

        // R6: disturb one wire of group 1 during chunk 2 only.
        a = mk_line(1);
        flip = '0;
        flip[2*BW + GW + 3] = 1'b1;
        send(a, a ^ flip, 4'b0100);
        while (rdy_n) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        bad_mask[GW + 3] = 1'b1;
        @(negedge clk);
        bad_mask = '0;
        wait_idle();

        // R6: a clean line afterwards reports no error.
        send(mk_line(7), mk_line(7), 4'b0);
        wait_idle();

        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule